// File: doc/BRIEF.md
# Unaligned DMA Write Byte Packer

This block sits on the memory-write side of a byte-wide peripheral DMA channel. A device hands it a stream of bytes, each with a parity bit. The block assembles the bytes into 32-bit longwords in little-endian lane order. Each completed longword is staged in a 32-entry buffer and then written to memory through a valid/ready longword port. The write address counts in longwords and advances once for each longword.

A transfer need not start or end on a longword boundary. When it starts off a boundary, the leading 1 to 3 bytes are kept in a leading holding register and not written to memory. When it ends off a boundary, the trailing 1 to 3 bytes are kept in a trailing holding register. Each holding register has one valid flag per byte lane, so software can merge the partial longwords itself.

A byte with bad parity stops the transfer and raises a sticky error flag. A completion interrupt rises once every byte has been received and every full longword has left the block.

Top module: `dma_wr_packer`

## Requirements
- R1: Reset clears the outputs. After reset, `in_ready`, `mem_wr_valid`, `done_irq` and `par_err` are 0, and both lane-valid fields are 0.
- R2: Byte lane and address mapping.
  - A byte whose byte address is A goes to lane A[1:0] (bits [8*L+7:8*L]) of longword A>>2.
  - Each full longword is written once, with `mem_wr_addr` = A>>2.
  - Successive writes use consecutive longword addresses, in order.
- R3: Leading partial longword.
  - This applies when the start address has A[1:0] != 0.
  - Bytes that fall in the first longword go to `lead_data`, and `lead_valid[L]` is set for each filled lane L.
  - That longword is never written to memory.
- R4: Trailing partial longword.
  - This applies when the transfer ends after lane k < 3 of a longword that is not the leading one.
  - The bytes of that longword go to `trail_data`, with `trail_valid` bits 0..k set.
  - Unfilled lanes of `trail_data` read 0.
- R5: The staging buffer holds 32 longwords, with one more longword in the output register. While memory never accepts a write, an aligned transfer is therefore accepted for exactly 132 bytes before `in_ready` stays low.
- R6: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold their values.
- R7: Parity is odd: a byte is good when `^{in_data,in_par}` is 1.
  - An accepted byte with bad parity sets the sticky `par_err`.
  - That byte is neither stored nor written.
  - `in_ready` then stays low until the next start.
- R8: Control byte.
  - `ctrl_byte[0]` enables the channel, and `ctrl_byte[1]` = 1 selects the device-to-memory direction.
  - Unless both bits are 1, `in_ready` stays low.
  - Bits 7:2 have no effect.
- R9: Clearing `ctrl_byte[0]` lets a write already presented on the port complete. No further write is presented until the bit is set again, and the transfer then resumes without losing data.
- R10: `done_irq` rises once the byte count is exhausted and every full longword has been accepted by memory. It stays high until the next start.
- R11: A start pulse clears `par_err`, `done_irq`, both holding registers and both lane-valid fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | Channel control: bit 0 enable, bit 1 direction (1 = to memory) |
| xfer_start | input | 1 | One-cycle pulse that loads address and count |
| xfer_addr | input | AW | Starting byte address |
| xfer_count | input | CW | Number of bytes in the transfer |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | 8 | Byte from the device |
| in_par | input | 1 | Odd parity bit for `in_data` |
| mem_wr_valid | output | 1 | Longword write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | AW-2 | Longword address |
| mem_wr_data | output | 32 | Longword data, lane 0 in bits 7:0 |
| lead_data | output | 32 | Leading partial longword |
| lead_valid | output | 4 | Per-lane valid for `lead_data` |
| trail_data | output | 32 | Trailing partial longword |
| trail_valid | output | 4 | Per-lane valid for `trail_data` |
| par_err | output | 1 | Sticky parity error flag |
| done_irq | output | 1 | Transfer complete |

## Verification
The packer is exercised with several kinds of transfer:
- An aligned transfer of whole longwords, which isolates lane packing and address stepping.
- A transfer unaligned at both ends, which separates the leading, middle and trailing cases.
- A single byte inside one longword, which must land in the leading register only.
- A short transfer with a toggling memory ready, which shows that the port holds under backpressure.

Further runs check the other behaviours:
- A long transfer against a stalled memory measures the exact buffer capacity.
- An enable drop in mid-transfer shows the one-write drain and the lossless resume.
- A bad-parity byte shows that the transfer stops and the error flag is set.
- A reversed-direction run, and a run with the upper control bits set, show which control bits matter.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
  localparam int LANES = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [LANES-1:0]  lane_mask_t;

  // odd parity: data plus parity bit must hold an odd number of ones
  function automatic logic odd_par_ok(byte_t d, logic p);
    return ^{d, p};
  endfunction

  // lanes 0..l set
  function automatic lane_mask_t lanes_upto(logic [1:0] l);
    case (l)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      2'd2:    return 4'b0111;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_pack_fifo.sv
module dma_pack_fifo #(
  parameter int W     = 62,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         allow,
  input  logic         take,
  output logic         full,
  output logic         empty,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CNTW = PW + 1;

  logic [W-1:0]    mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic [CNTW-1:0] cnt;
  logic            load;

  assign full  = (cnt == CNTW'(DEPTH));
  assign empty = (cnt == '0);
  assign load  = allow && !empty && (!out_valid || take);

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (load) out_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt <= '0;
      out_valid <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (load) rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CNTW'(push) - CNTW'(load);
      if (load) out_valid <= 1'b1;
      else if (take) out_valid <= 1'b0;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < CNTW'(DEPTH)));
endmodule

// File: rtl/dma_byte_assembler.sv
module dma_byte_assembler
  import dma_pack_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] count,
  input  logic          go,
  input  logic          fifo_full,
  input  logic          in_valid,
  input  byte_t         in_data,
  input  logic          in_par,
  output logic          in_ready,
  output logic          push,
  output logic [AW-3:0] push_addr,
  output logic [31:0]   push_data,
  output logic [31:0]   lead_data,
  output lane_mask_t    lead_valid,
  output logic [31:0]   trail_data,
  output lane_mask_t    trail_valid,
  output logic          par_err,
  output logic          finished
);
  logic          active, head;
  logic [1:0]    lane;
  logic [AW-3:0] waddr;
  logic [CW-1:0] left;
  logic [31:0]   asm_w, cur;
  logic          accept, good;

  assign in_ready  = active && go && !fifo_full;
  assign accept    = in_valid && in_ready;
  assign good      = odd_par_ok(in_data, in_par);
  assign push      = accept && good && !head && (lane == 2'd3);
  assign push_addr = waddr;
  assign push_data = cur;

  always_comb begin
    cur = asm_w;
    cur[lane*8 +: 8] = in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0; head <= 1'b0; lane <= '0; waddr <= '0; left <= '0;
      asm_w <= '0; lead_data <= '0; lead_valid <= '0;
      trail_data <= '0; trail_valid <= '0; par_err <= 1'b0; finished <= 1'b0;
    end else if (start) begin
      active <= (count != '0);
      finished <= (count == '0);
      head <= (start_addr[1:0] != 2'd0);
      lane <= start_addr[1:0];
      waddr <= start_addr[AW-1:2];
      left <= count;
      lead_data <= '0; lead_valid <= '0;
      trail_data <= '0; trail_valid <= '0;
      par_err <= 1'b0;
    end else if (accept) begin
      if (!good) begin
        par_err <= 1'b1;
        active <= 1'b0;
      end else begin
        lane <= lane + 2'd1;
        left <= left - 1'b1;
        if (head) begin
          lead_data[lane*8 +: 8] <= in_data;
          lead_valid[lane] <= 1'b1;
        end else begin
          asm_w[lane*8 +: 8] <= in_data;
        end
        if (lane == 2'd3) begin
          head <= 1'b0;
          waddr <= waddr + 1'b1;
        end
        if (left == CW'(1)) begin
          active <= 1'b0;
          finished <= 1'b1;
          if (!head && lane != 2'd3) begin
            trail_data <= cur & {{8{lanes_upto(lane)[3]}}, {8{lanes_upto(lane)[2]}},
                                 {8{lanes_upto(lane)[1]}}, {8{lanes_upto(lane)[0]}}};
            trail_valid <= lanes_upto(lane);
          end
        end
      end
    end
  end

  // R3
  lead_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!head && !start) |=> $stable(lead_valid));

  // R7
  err_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    par_err |-> !in_ready);
endmodule

// File: rtl/dma_wr_packer.sv
module dma_wr_packer
  import dma_pack_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CW    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    ctrl_byte,
  input  logic          xfer_start,
  input  logic [AW-1:0] xfer_addr,
  input  logic [CW-1:0] xfer_count,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_par,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-3:0] mem_wr_addr,
  output logic [31:0]   mem_wr_data,
  output logic [31:0]   lead_data,
  output logic [3:0]    lead_valid,
  output logic [31:0]   trail_data,
  output logic [3:0]    trail_valid,
  output logic          par_err,
  output logic          done_irq
);
  localparam int LWA = AW - 2;
  localparam int EW  = LWA + WORD_W;

  logic           enable, go, ctrl_unused;
  logic           push, fifo_full, fifo_empty, finished;
  logic [LWA-1:0] push_addr;
  logic [31:0]    push_data;
  logic [EW-1:0]  out_entry;

  assign enable      = ctrl_byte[0];
  assign go          = ctrl_byte[0] && ctrl_byte[1];
  assign ctrl_unused = ^ctrl_byte[7:2];

  dma_byte_assembler #(.AW(AW), .CW(CW)) u_asm (
    .clk(clk), .rst(rst), .start(xfer_start), .start_addr(xfer_addr),
    .count(xfer_count), .go(go), .fifo_full(fifo_full),
    .in_valid(in_valid), .in_data(in_data), .in_par(in_par),
    .in_ready(in_ready), .push(push), .push_addr(push_addr),
    .push_data(push_data), .lead_data(lead_data), .lead_valid(lead_valid),
    .trail_data(trail_data), .trail_valid(trail_valid),
    .par_err(par_err), .finished(finished)
  );

  dma_pack_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(xfer_start), .push(push),
    .push_data({push_addr, push_data}), .allow(enable),
    .take(mem_wr_valid && mem_wr_ready), .full(fifo_full),
    .empty(fifo_empty), .out_valid(mem_wr_valid), .out_data(out_entry)
  );

  assign mem_wr_addr = out_entry[EW-1:WORD_W];
  assign mem_wr_data = out_entry[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || xfer_start) done_irq <= 1'b0;
    else done_irq <= finished && fifo_empty && !mem_wr_valid;
  end

  // R6
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready && !xfer_start) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R9
  drain_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_byte[0] && !(mem_wr_valid && !mem_wr_ready)) |=> !mem_wr_valid);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> (!mem_wr_valid && !in_ready));
endmodule

// File: tb/tb_dma_wr_packer.sv
module tb_dma_wr_packer;
  logic        clk = 0, rst = 1;
  logic [7:0]  ctrl_byte = 8'h03;
  logic        xfer_start = 0;
  logic [31:0] xfer_addr = 0;
  logic [15:0] xfer_count = 0;
  logic        in_valid = 0, in_par = 0;
  logic [7:0]  in_data = 0;
  logic        in_ready, mem_wr_valid, mem_wr_ready;
  logic [29:0] mem_wr_addr;
  logic [31:0] mem_wr_data, lead_data, trail_data;
  logic [3:0]  lead_valid, trail_valid;
  logic        par_err, done_irq;

  int tests = 0, fails = 0, wr_seen = 0;
  logic [1:0] rdy_mode = 0;
  logic tog = 0;
  logic [61:0] exp_q[$];

  logic [31:0] m_ptr, m_start;
  int m_left;
  logic [31:0] m_acc, e_lead, e_trail;
  logic [3:0] e_lead_v, e_trail_v;

  always #4 clk = ~clk;
  always @(negedge clk) tog <= ~tog;
  assign mem_wr_ready = (rdy_mode == 2) ? tog : rdy_mode[0];

  dma_wr_packer dut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard compare of every accepted memory write
  always begin
    @(negedge clk); #2;
    if (!rst && mem_wr_valid && mem_wr_ready) begin
      wr_seen++;
      if (exp_q.size() == 0) check(0, "R2 unexpected write", {mem_wr_addr, mem_wr_data}, 0);
      else begin
        logic [61:0] e;
        e = exp_q.pop_front();
        check({mem_wr_addr, mem_wr_data} == e, "R2 write addr/data", {mem_wr_addr, mem_wr_data}, e);
      end
    end
  end

  task automatic start_xfer(input logic [31:0] a, input int n);
    @(negedge clk);
    xfer_addr = a; xfer_count = 16'(n); xfer_start = 1;
    m_ptr = a; m_start = a; m_left = n; m_acc = 0;
    e_lead = 0; e_trail = 0; e_lead_v = 0; e_trail_v = 0;
    @(negedge clk);
    xfer_start = 0;
  endtask

  // drives one byte; ok reports acceptance within maxwait cycles
  task automatic send_byte(input logic [7:0] b, input bit good, input int maxwait, output bit ok);
    int w = 0;
    @(negedge clk);
    while (!in_ready && w < maxwait) begin in_valid = 0; @(negedge clk); w++; end
    ok = in_ready;
    if (!ok) begin in_valid = 0; return; end
    in_data = b; in_par = good ? ~^b : ^b; in_valid = 1;
    @(posedge clk);
    if (good) begin
      int ln = m_ptr[1:0];
      if (m_start[1:0] != 0 && m_ptr[31:2] == m_start[31:2]) begin
        e_lead[ln*8 +: 8] = b; e_lead_v[ln] = 1;
      end else begin
        m_acc[ln*8 +: 8] = b;
        if (ln == 3) exp_q.push_back({m_ptr[31:2], m_acc});
        else if (m_left == 1) begin
          for (int k = 0; k <= ln; k++) begin e_trail[k*8 +: 8] = m_acc[k*8 +: 8]; e_trail_v[k] = 1; end
        end
      end
      m_ptr++; m_left--;
    end
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 0;
  endtask

  task automatic send_all(input int n, input logic [7:0] seed);
    bit ok;
    for (int i = 0; i < n; i++) begin
      send_byte(seed + 8'(i), 1, 5000, ok);
      if (!ok) check(0, "R2 byte not accepted", i, n);
    end
    idle();
  endtask

  task automatic wait_done(input string req);
    int w = 0;
    while (!done_irq && w < 3000) begin @(negedge clk); w++; end
    check(done_irq, req, done_irq, 1);
  endtask

  task automatic check_holds(input string req);
    check(lead_valid == e_lead_v, {req, " lead_valid"}, lead_valid, e_lead_v);
    check(lead_data == e_lead, {req, " lead_data"}, lead_data, e_lead);
    check(trail_valid == e_trail_v, {req, " trail_valid"}, trail_valid, e_trail_v);
    check(trail_data == e_trail, {req, " trail_data"}, trail_data, e_trail);
    check(exp_q.size() == 0, {req, " pending writes"}, exp_q.size(), 0);
  endtask

  initial begin
    #1500000;
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit ok;
    int acc, base;
    rdy_mode = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!in_ready && !mem_wr_valid && !done_irq && !par_err, "R1 idle outputs",
          {in_ready, mem_wr_valid, done_irq, par_err}, 0);
    check(lead_valid == 0 && trail_valid == 0, "R1 lane valids", {lead_valid, trail_valid}, 0);

    // R2 aligned transfer, whole longwords
    start_xfer(32'h100, 16); send_all(16, 8'hA0);
    wait_done("R10 done aligned"); check_holds("R2 aligned");
    check(wr_seen == 4, "R2 write count", wr_seen, 4);

    // R3 R4 unaligned at both ends
    start_xfer(32'h201, 10); send_all(10, 8'h10);
    wait_done("R10 done unaligned"); check_holds("R3 R4 unaligned");
    check(lead_valid == 4'b1110 && trail_valid == 4'b0111, "R3 R4 lane masks",
          {lead_valid, trail_valid}, 8'hE7);

    // R3 single byte inside one longword
    start_xfer(32'h302, 1); send_all(1, 8'h5C);
    wait_done("R10 done single"); check_holds("R3 single byte");

    // R11 start clears holding state
    start_xfer(32'h380, 4);
    check(lead_valid == 0 && lead_data == 0 && !done_irq, "R11 start clears",
          {lead_valid, lead_data, done_irq}, 0);
    send_all(4, 8'h70); wait_done("R10 done after clear"); check_holds("R11 follow-on");

    // R6 backpressure with toggling ready
    rdy_mode = 2;
    start_xfer(32'h400, 13); send_all(13, 8'h30);
    wait_done("R6 done under backpressure"); check_holds("R6 R4 toggling");
    rdy_mode = 1;

    // R5 buffer capacity against a stalled memory
    rdy_mode = 0;
    start_xfer(32'h0, 160);
    acc = 0;
    for (int i = 0; i < 160; i++) begin
      send_byte(8'(i), 1, 20, ok);
      if (!ok) break;
      acc++;
    end
    idle();
    check(acc == 132, "R5 bytes accepted before stall", acc, 132);
    rdy_mode = 1;
    for (int i = acc; i < 160; i++) begin
      send_byte(8'(i), 1, 5000, ok);
      if (!ok) check(0, "R5 resume", i, 160);
    end
    idle();
    wait_done("R5 done after drain"); check_holds("R5 drain");

    // R9 enable cleared in mid-transfer
    rdy_mode = 0;
    start_xfer(32'h800, 24); send_all(24, 8'h40);
    repeat (3) @(negedge clk);
    ctrl_byte = 8'h02; base = wr_seen;
    rdy_mode = 1;
    repeat (12) @(negedge clk);
    check(wr_seen - base == 1, "R9 one write drains", wr_seen - base, 1);
    check(!done_irq, "R9 not done while disabled", done_irq, 0);
    ctrl_byte = 8'h03;
    wait_done("R9 done after resume"); check_holds("R9 resume");
    check(wr_seen - base == 6, "R9 all writes after resume", wr_seen - base, 6);

    // R7 parity error
    start_xfer(32'h900, 8);
    send_byte(8'h11, 1, 100, ok); send_byte(8'h22, 1, 100, ok);
    send_byte(8'h33, 0, 100, ok); idle();
    check(par_err, "R7 error flag", par_err, 1);
    check(!in_ready, "R7 ready low", in_ready, 0);
    base = wr_seen;
    repeat (10) @(negedge clk);
    check(wr_seen == base && !done_irq, "R7 no write, no done", {wr_seen - base, done_irq}, 0);
    start_xfer(32'hA00, 4);
    check(!par_err, "R11 error cleared", par_err, 0);
    send_all(4, 8'h90); wait_done("R10 done after error"); check_holds("R7 recover");

    // R8 direction toward device: no bytes accepted
    ctrl_byte = 8'h01;
    start_xfer(32'hB00, 4);
    ok = 0;
    repeat (10) begin @(negedge clk); if (in_ready) ok = 1; end
    check(!ok, "R8 reversed direction blocks input", ok, 0);

    // R8 upper control bits ignored
    ctrl_byte = 8'hFF;
    start_xfer(32'hC00, 8); send_all(8, 8'hE0);
    wait_done("R8 done with upper bits set"); check_holds("R8 upper bits");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule